// File: doc/BRIEF.md
# Byte ALU with Status Flag Generation

This block is the purely combinational arithmetic and logic datapath of a small 8-bit accumulator machine. Each cycle the surrounding sequencer presents an operation code, the accumulator value, a second operand taken from data memory or from an immediate field, and the current status flags. The block returns the 8-bit result, the next value of each of the four status flags (carry, half carry, zero, overflow), and one update-enable bit per flag. The sequencer commits a flag only when its enable is high. The flag outputs already echo the incoming flag whenever the enable is low, so the sequencer can also take them unconditionally.

The operation set covers binary add and subtract, with and without the incoming carry. It also covers BCD correction of the accumulator, bitwise AND, OR, XOR and complement, plain and through-carry rotates in both directions, and increment and decrement. Four test operations drive a skip output that the sequencer uses for conditional skip branches. Subtraction follows the "carry means no borrow" convention. The block has no clock, no reset and no state, so there are no states or transitions to name. Sequencing and register writeback belong to the surrounding logic.

Top module: `alu8_core`

## Requirements
- R1: For ADD (op 0) and ADDC (op 1), res is (opa + opb + k) mod 256, with k = 0 for ADD and k = c_in for ADDC. c_out is the carry out of bit 7. ac_out is the carry out of bit 3. All four update bits are 1, and z_out = (res == 0).
- R2: For SUB (op 2) and SUBB (op 3), res is (opa + ~opb + k) mod 256, with k = 1 for SUB and k = c_in for SUBB. c_out = 1 when no borrow occurs. ac_out = 1 when the low nibble needs no borrow. All four update bits are 1, and z_out = (res == 0).
- R3: For ops 0 to 3, ov_out is 1 exactly when the signed two's-complement result leaves the range -128 to 127. This is the XOR of the carry into bit 7 and the carry out of bit 7.
- R4: DECADJ (op 4) builds t = opa + 6 when the low nibble of opa exceeds 9 or ac_in is 1, and t = opa otherwise. If bits 7:4 of t exceed 9, or c_in is 1, or t passed 255, then res = (t + 0x60) mod 256 and c_out = 1. Otherwise res = t mod 256 and c_out = 0. Only upd_c is 1.
- R5: AND (op 5), OR (op 6) and XOR (op 7) combine opa with opb, and CPL (op 8) inverts opa. Only upd_z is 1.
- R6: INC (op 13) and DEC (op 14) give opa + 1 and opa - 1 mod 256. Only upd_z is 1.
- R7: ROL (op 9) and ROR (op 10) rotate opa by one bit within itself. No update bit is set.
- R8: ROLC (op 11) and RORC (op 12) rotate the 9-bit value formed by c_in and opa. The bit shifted out becomes c_out, and only upd_c is 1.
- R9: TSTZ (op 15) and TSTNZ (op 16) give res = opa and skip = (opa == 0), respectively (opa != 0). No update bit is set.
- R10: INCSKZ (op 17) and DECSKZ (op 18) give res = opa + 1 (respectively opa - 1) mod 256, and skip = (res == 0). No update bit is set.
- R11: Any flag whose update bit is 0 appears at its output unchanged from its input (c_in, ac_in, z_in, ov_in).
- R12: Op codes 19 to 31 give res = opa, skip = 0 and no update bits. Skip is 0 for every op other than 15 to 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code (encodings in R1 to R12) |
| opa | input | 8 | Accumulator operand |
| opb | input | 8 | Memory or immediate operand |
| c_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current half-carry flag |
| z_in | input | 1 | Current zero flag |
| ov_in | input | 1 | Current overflow flag |
| res | output | 8 | Operation result |
| c_out | output | 1 | Next carry flag |
| ac_out | output | 1 | Next half-carry flag |
| z_out | output | 1 | Next zero flag |
| ov_out | output | 1 | Next overflow flag |
| upd_c | output | 1 | Carry flag is written by this op |
| upd_ac | output | 1 | Half-carry flag is written by this op |
| upd_z | output | 1 | Zero flag is written by this op |
| upd_ov | output | 1 | Overflow flag is written by this op |
| skip | output | 1 | Skip condition for test operations |

## Verification
Every op code, including the undefined ones, is applied with all 256 accumulator values. Each of these is paired with sixteen second operands chosen around nibble and sign boundaries (0, 1, 7, 8, 9, 0x0F, 0x10, 0x55, 0x7F, 0x80, 0x81, 0x99, 0xA0, 0xF0, 0xFE, 0xFF), and with both carry values. The sign-boundary operands separate a correct overflow from one taken from carry alone. The nibble-boundary operands separate the half-carry and the BCD correction thresholds. The incoming half-carry, zero and overflow flags are varied with the operands, so that any masked flag that fails to pass through shows up as a mismatch. Overflow gets its own separate comparison on the four binary add and subtract ops.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD    = 5'd0,
        OP_ADDC   = 5'd1,
        OP_SUB    = 5'd2,
        OP_SUBB   = 5'd3,
        OP_DECADJ = 5'd4,
        OP_AND    = 5'd5,
        OP_OR     = 5'd6,
        OP_XOR    = 5'd7,
        OP_CPL    = 5'd8,
        OP_ROL    = 5'd9,
        OP_ROR    = 5'd10,
        OP_ROLC   = 5'd11,
        OP_RORC   = 5'd12,
        OP_INC    = 5'd13,
        OP_DEC    = 5'd14,
        OP_TSTZ   = 5'd15,
        OP_TSTNZ  = 5'd16,
        OP_INCSKZ = 5'd17,
        OP_DECSKZ = 5'd18
    } op_e;

    typedef struct packed {
        logic c;
        logic ac;
        logic z;
        logic ov;
    } flags_t;

    function automatic logic is_arith(input logic [4:0] code);
        return code <= 5'd3;
    endfunction

    function automatic logic is_test(input logic [4:0] code);
        return (code >= 5'd15) && (code <= 5'd18);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          invert,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hcout,
    output logic          ovf
);
    localparam int HW = DW / 2;

    logic [DW-1:0] yy;
    logic [DW-1:0] low_part;   // bits DW-2:0 plus carry into msb
    logic [HW:0]   half_part;
    logic          c_msb_in;
    logic          msb;

    always_comb begin
        yy        = invert ? ~y : y;
        low_part  = {1'b0, x[DW-2:0]} + {1'b0, yy[DW-2:0]} + {{(DW-1){1'b0}}, cin};
        c_msb_in  = low_part[DW-1];
        msb       = x[DW-1] ^ yy[DW-1] ^ c_msb_in;
        cout      = (x[DW-1] & yy[DW-1]) | (x[DW-1] & c_msb_in) | (yy[DW-1] & c_msb_in);
        half_part = {1'b0, x[HW-1:0]} + {1'b0, yy[HW-1:0]} + {{HW{1'b0}}, cin};
        hcout     = half_part[HW];
        sum       = {msb, low_part[DW-2:0]};
        ovf       = c_msb_in ^ cout;
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]    code,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] y,
    output logic          cout
);
    always_comb begin
        y    = a;
        cout = cin;
        case (code)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_CPL:  y = ~a;
            OP_ROL:  y = {a[DW-2:0], a[DW-1]};
            OP_ROR:  y = {a[0], a[DW-1:1]};
            OP_ROLC: begin
                y    = {a[DW-2:0], cin};
                cout = a[DW-1];
            end
            OP_RORC: begin
                y    = {cin, a[DW-1:1]};
                cout = a[0];
            end
            default: y = a;
        endcase
    end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic          acin,
    output logic [DW-1:0] y,
    output logic          cout
);
    localparam int HW = DW / 2;
    localparam logic [HW-1:0] DIGIT_MAX = HW'(9);
    localparam logic [DW:0]   LOW_FIX   = (DW+1)'(6);
    localparam logic [DW:0]   HIGH_FIX  = (DW+1)'(6) << HW;

    logic [DW:0] stage1;
    logic [DW:0] stage2;
    logic        low_need;
    logic        high_need;

    always_comb begin
        low_need  = (a[HW-1:0] > DIGIT_MAX) | acin;
        stage1    = {1'b0, a} + (low_need ? LOW_FIX : '0);
        high_need = (stage1[DW-1:HW] > DIGIT_MAX) | cin | stage1[DW];
        stage2    = stage1 + (high_need ? HIGH_FIX : '0);
        y         = stage2[DW-1:0];
        cout      = high_need;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          c_in,
    input  logic          ac_in,
    input  logic          z_in,
    input  logic          ov_in,
    output logic [DW-1:0] res,
    output logic          c_out,
    output logic          ac_out,
    output logic          z_out,
    output logic          ov_out,
    output logic          upd_c,
    output logic          upd_ac,
    output logic          upd_z,
    output logic          upd_ov,
    output logic          skip
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] as_sum;
    logic          as_c;
    logic          as_hc;
    logic          as_ov;
    logic          as_inv;
    logic          as_cin;

    logic [DW-1:0] bo_y;
    logic          bo_c;
    logic [DW-1:0] da_y;
    logic          da_c;

    logic [DW-1:0] inc_v;
    logic [DW-1:0] dec_v;

    always_comb begin
        as_inv = (op == OP_SUB) || (op == OP_SUBB);
        case (op)
            OP_ADD:  as_cin = 1'b0;
            OP_SUB:  as_cin = 1'b1;
            default: as_cin = c_in;
        endcase
        inc_v = opa + ONE;
        dec_v = opa - ONE;
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .x(opa), .y(opb), .invert(as_inv), .cin(as_cin),
        .sum(as_sum), .cout(as_c), .hcout(as_hc), .ovf(as_ov)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .code(op), .a(opa), .b(opb), .cin(c_in), .y(bo_y), .cout(bo_c)
    );

    alu8_decadj #(.DW(DW)) u_decadj (
        .a(opa), .cin(c_in), .acin(ac_in), .y(da_y), .cout(da_c)
    );

    logic [DW-1:0] res_v;
    flags_t        nxt;
    flags_t        upd;
    logic          skp;

    always_comb begin
        res_v = opa;
        nxt   = '{c: c_in, ac: ac_in, z: z_in, ov: ov_in};
        upd   = '0;
        skp   = 1'b0;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                res_v  = as_sum;
                nxt.c  = as_c;
                nxt.ac = as_hc;
                nxt.ov = as_ov;
                upd    = '{c: 1'b1, ac: 1'b1, z: 1'b1, ov: 1'b1};
            end
            OP_DECADJ: begin
                res_v = da_y;
                nxt.c = da_c;
                upd.c = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                res_v = bo_y;
                upd.z = 1'b1;
            end
            OP_ROL, OP_ROR: begin
                res_v = bo_y;
            end
            OP_ROLC, OP_RORC: begin
                res_v = bo_y;
                nxt.c = bo_c;
                upd.c = 1'b1;
            end
            OP_INC: begin
                res_v = inc_v;
                upd.z = 1'b1;
            end
            OP_DEC: begin
                res_v = dec_v;
                upd.z = 1'b1;
            end
            OP_TSTZ:   skp = (opa == '0);
            OP_TSTNZ:  skp = (opa != '0);
            OP_INCSKZ: begin
                res_v = inc_v;
                skp   = (inc_v == '0);
            end
            OP_DECSKZ: begin
                res_v = dec_v;
                skp   = (dec_v == '0);
            end
            default: res_v = opa;
        endcase
        if (upd.z) nxt.z = (res_v == '0);

        if (!$isunknown({op, opa, opb, c_in, ac_in, z_in, ov_in})) begin
            // R12: skip only from the four test ops
            a_r12_skip_source: assert (!skp || is_test(op))
                else $error("skip raised by non-test op %0d", op);
            // R5 / R6: logic and inc/dec touch only Z
            a_r5_z_only_mask: assert (!((op >= 5'd5 && op <= 5'd8) || op == 5'd13 || op == 5'd14)
                                      || (upd == 4'b0010))
                else $error("wrong mask for op %0d", op);
            // R11: unwritten carry passes through
            a_r11_carry_hold: assert (upd.c || nxt.c == c_in)
                else $error("carry changed without update");
            // R2: no-borrow convention on plain subtract
            a_r2_no_borrow: assert (op != OP_SUB || nxt.c == (opa >= opb))
                else $error("subtract carry mismatch");
            // R1: add carry equals unsigned wrap-around
            a_r1_add_carry: assert (op != OP_ADD || nxt.c == (opa > ~opb))
                else $error("add carry mismatch");
            // R3: overflow only written by binary arithmetic
            a_r3_ov_scope: assert (!upd.ov || is_arith(op))
                else $error("overflow written by op %0d", op);
        end
    end

    assign res    = res_v;
    assign c_out  = nxt.c;
    assign ac_out = nxt.ac;
    assign z_out  = nxt.z;
    assign ov_out = nxt.ov;
    assign upd_c  = upd.c;
    assign upd_ac = upd.ac;
    assign upd_z  = upd.z;
    assign upd_ov = upd.ov;
    assign skip   = skp;

endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [4:0] op;
    logic [7:0] opa, opb, res;
    logic c_in, ac_in, z_in, ov_in;
    logic c_out, ac_out, z_out, ov_out;
    logic upd_c, upd_ac, upd_z, upd_ov, skip;

    alu8_core uut (
        .op(op), .opa(opa), .opb(opb), .c_in(c_in), .ac_in(ac_in),
        .z_in(z_in), .ov_in(ov_in), .res(res), .c_out(c_out),
        .ac_out(ac_out), .z_out(z_out), .ov_out(ov_out),
        .upd_c(upd_c), .upd_ac(upd_ac), .upd_z(upd_z), .upd_ov(upd_ov),
        .skip(skip)
    );

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    logic [7:0] bset [16] = '{8'h00, 8'h01, 8'h07, 8'h08, 8'h09, 8'h0F, 8'h10, 8'h55,
                              8'h7F, 8'h80, 8'h81, 8'h99, 8'hA0, 8'hF0, 8'hFE, 8'hFF};

    function automatic string tag(input int o);
        if (o <= 1) return "R1";
        if (o <= 3) return "R2";
        if (o == 4) return "R4";
        if (o <= 8) return "R5";
        if (o <= 10) return "R7";
        if (o <= 12) return "R8";
        if (o <= 14) return "R6";
        if (o <= 16) return "R9";
        if (o <= 18) return "R10";
        return "R12";
    endfunction

    // packed: {res[7:0], c, ac, z, ov, uc, uac, uz, uov, skip}
    function automatic logic [16:0] model(input int o, input int a, input int b,
                                          input int ci, input int aci, input int zi, input int ovi);
        int r, c, ac, z, ov, uc, uac, uz, uov, sk, s, k, sv, sa, sb, t, up;
        r = a; c = ci; ac = aci; z = zi; ov = ovi;
        uc = 0; uac = 0; uz = 0; uov = 0; sk = 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (o)
            0, 1: begin
                k = (o == 1) ? ci : 0;
                s = a + b + k; r = s % 256; c = (s > 255);
                ac = ((a % 16) + (b % 16) + k) > 15;
                sv = sa + sb + k; ov = (sv > 127 || sv < -128);
                uc = 1; uac = 1; uz = 1; uov = 1;
            end
            2, 3: begin
                k = (o == 3) ? ci : 1;
                s = a + (255 - b) + k; r = s % 256; c = (s > 255);
                ac = ((a % 16) + (15 - b % 16) + k) > 15;
                sv = sa - sb - 1 + k; ov = (sv > 127 || sv < -128);
                uc = 1; uac = 1; uz = 1; uov = 1;
            end
            4: begin
                t = a + (((a % 16) > 9 || aci) ? 6 : 0);
                up = (((t / 16) % 16) > 9) || ci || (t > 255);
                r = (t + (up ? 96 : 0)) % 256; c = up; uc = 1;
            end
            5: begin r = a & b; uz = 1; end
            6: begin r = a | b; uz = 1; end
            7: begin r = a ^ b; uz = 1; end
            8: begin r = 255 - a; uz = 1; end
            9:  r = (a * 2) % 256 + a / 128;
            10: r = a / 2 + (a % 2) * 128;
            11: begin r = (a * 2) % 256 + ci; c = a / 128; uc = 1; end
            12: begin r = a / 2 + ci * 128; c = a % 2; uc = 1; end
            13: begin r = (a + 1) % 256; uz = 1; end
            14: begin r = (a + 255) % 256; uz = 1; end
            15: sk = (a == 0);
            16: sk = (a != 0);
            17: begin r = (a + 1) % 256; sk = (r == 0); end
            18: begin r = (a + 255) % 256; sk = (r == 0); end
            default: r = a;
        endcase
        if (uz) z = (r == 0);
        return {r[7:0], c[0], ac[0], z[0], ov[0], uc[0], uac[0], uz[0], uov[0], sk[0]};
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h ci=%0d: got %h expected %h",
                     req, op, opa, opb, c_in, act, exp);
        end
    endtask

    initial begin
        logic [16:0] e, g;
        op = 5'd0; opa = 8'h00; opb = 8'h00;
        c_in = 1'b0; ac_in = 1'b0; z_in = 1'b0; ov_in = 1'b0;
        #2;
        // initial vector: 0 + 0 gives zero with Z set (R1)
        g = {res, c_out, ac_out, z_out, ov_out, upd_c, upd_ac, upd_z, upd_ov, skip};
        check("R1", g, model(0, 0, 0, 0, 0, 0, 0));
        for (int o = 0; o < 32; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        op    = o[4:0];
                        opa   = a[7:0];
                        opb   = bset[bi];
                        c_in  = ci[0];
                        ac_in = a[0] ^ bi[1];
                        z_in  = a[1] ^ bi[0] ^ ci[0];   // R11 pass-through pattern
                        ov_in = a[2] ^ bi[2];
                        #1;
                        e = model(o, a, int'(bset[bi]), ci, int'(ac_in), int'(z_in), int'(ov_in));
                        g = {res, c_out, ac_out, z_out, ov_out, upd_c, upd_ac, upd_z, upd_ov, skip};
                        check(tag(o), g, e);
                        if (o <= 3) check("R3", {16'h0, ov_out}, {16'h0, e[5]});
                        if (!e[4] && !e[3] && !e[2] && !e[1])
                            check("R11", {13'h0, c_out, ac_out, z_out, ov_out},
                                  {13'h0, c_in, ac_in, z_in, ov_in});
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_400_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule